// File: doc/BRIEF.md
# Configurable Logic Cell

A behavioural model of one programmable cell: a four-input lookup table whose truth table is a 16-bit configuration word, a one-bit carry slice for cascaded arithmetic, and a flip-flop whose next-state rule is set by configuration. It can act as a D, toggle, JK or set/reset flip-flop. Configuration also picks which of two shared clocks drives the flip-flop and which of two shared clock enables gates it. A further bit routes either the table result or the stored bit to the cell output.

Layered controls act on the flip-flop. An active-low chip reset, an asynchronous clear and an asynchronous preset take effect without a clock edge. A shared synchronous clear and a shared synchronous load act at the selected clock edge. The table result, the stored bit, the selected cell output and the carry-out are all visible as ports.

Top module: `logic_cell`

## Requirements
- R1: With `cfg_arith`=0, `comb_out` equals `cfg_mask[idx]`, where idx is the 4-bit number {din[3],din[2],din[1],din[0]}.
- R2: With `cfg_arith`=1, `comb_out` = din[0] xor din[1] xor `cin` and `cout` = majority(din[0], din[1], `cin`), whatever `cfg_mask` holds. With `cfg_arith`=0, `cout` equals `cin`.
- R3: `cell_out` equals `comb_out` when `cfg_bypass`=1 and equals `reg_q` when `cfg_bypass`=0.
- R4: The flip-flop changes only on rising edges of `clk_a` when `cfg_clk_sel`=0 and only on rising edges of `clk_b` when `cfg_clk_sel`=1.
- R5: The enable is `ena_a` when `cfg_ena_sel`=0 and `ena_b` when it is 1. With the enable low and no synchronous control, `reg_q` holds.
- R6: `cfg_mode`=0 (D): an enabled edge stores the table result.
- R7: `cfg_mode`=1 (toggle): an enabled edge inverts `reg_q` when the table result is 1 and holds it when the result is 0.
- R8: `cfg_mode`=2 (JK): J is the table result and K is din[3]. An enabled edge holds for 00, sets for J=1 K=0, clears for J=0 K=1 and inverts for 11.
- R9: `cfg_mode`=3 (SR): S is the table result and R is din[3]. An enabled edge sets for S=1 R=0 and clears for S=0 R=1. It holds both when both are 0 and when both are 1.
- R10: `sclr` high at a selected edge stores 0. It wins over `sload` and acts whatever the enable.
- R11: `sload` high (with `sclr` low) at a selected edge stores din[2], in every mode and whatever the enable.
- R12: `aclr` high forces `reg_q` to 0 at once, with no clock edge, and wins over `apre` and all synchronous controls.
- R13: `apre` high, with `aclr` low, forces `reg_q` to 1 at once, with no clock edge.
- R14: `rst_n` low forces `reg_q` to 0 at once and wins over every other control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Shared clock A |
| clk_b | input | 1 | Shared clock B |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| ena_a | input | 1 | Shared clock enable A |
| ena_b | input | 1 | Shared clock enable B |
| aclr | input | 1 | Asynchronous clear |
| apre | input | 1 | Asynchronous preset |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load of din[2] |
| cfg_mask | input | 16 | Lookup table truth table |
| cfg_mode | input | 2 | Flip-flop rule: 0 D, 1 toggle, 2 JK, 3 SR |
| cfg_arith | input | 1 | 1 selects the arithmetic sum and carry |
| cfg_clk_sel | input | 1 | 0 clk_a, 1 clk_b |
| cfg_ena_sel | input | 1 | 0 ena_a, 1 ena_b |
| cfg_bypass | input | 1 | 1 routes the table result to cell_out |
| din | input | 4 | Table data inputs |
| cin | input | 1 | Carry in |
| comb_out | output | 1 | Table or sum result |
| reg_q | output | 1 | Stored bit |
| cell_out | output | 1 | Selected cell output |
| cout | output | 1 | Carry out |

## Verification
The clocked assertions compare `reg_q` between two consecutive selected edges. They therefore assume that no asynchronous clear, preset or reset pulse begins and ends between those edges. They also assume that `cfg_clk_sel` changes only while both clocks are low, so that the clock mux makes no false edge. The stimulus raises and lowers every asynchronous control at a falling edge of `clk_a` and holds it across at least one selected edge. The stimulus moves the clock select only after finding a falling edge of `clk_a` at which `clk_b` is also low.

// File: rtl/lcell_pkg.sv
// Shared types and helpers for the configurable logic cell.
// Assumes: the mode encoding below matches the cfg_mode port of the top.
package lcell_pkg;

    typedef enum logic [1:0] {
        MODE_D  = 2'd0,
        MODE_T  = 2'd1,
        MODE_JK = 2'd2,
        MODE_SR = 2'd3
    } ff_mode_e;

    // Majority of three bits, used as the carry of a full adder.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lcell_table.sv
// Lookup table plus carry slice.
// Normal mode: the result is the mask bit addressed by din.
// Arithmetic mode: the result is a full-adder sum of din[0], din[1] and cin.
// Assumes: LUT_INPUTS >= 2 so that din[1] exists.
module lcell_table #(
    parameter int LUT_INPUTS = 4,
    localparam int MASK_W    = 1 << LUT_INPUTS
) (
    input  logic [MASK_W-1:0]     mask,
    input  logic [LUT_INPUTS-1:0] din,
    input  logic                  cin,
    input  logic                  arith,
    output logic                  tbl,
    output logic                  cout
);
    import lcell_pkg::*;

    logic lut_bit;
    logic sum_bit;

    // Truth-table lookup and full-adder sum, side by side.
    always_comb begin
        lut_bit = mask[din];
        sum_bit = din[0] ^ din[1] ^ cin;
    end

    // Pick the result; the carry ripples through when not in arithmetic mode.
    always_comb begin
        tbl  = arith ? sum_bit : lut_bit;
        cout = arith ? maj3(din[0], din[1], cin) : cin;
    end
endmodule

// File: rtl/lcell_update.sv
// Next-state rule of the flip-flop for each configurable mode.
// The table result is the first control term; ctl (din[3]) is the second.
// Assumes: the result feeds a register that applies it only when enabled.
module lcell_update (
    input  lcell_pkg::ff_mode_e mode,
    input  logic                q,
    input  logic                tbl,
    input  logic                ctl,
    output logic                nxt
);
    import lcell_pkg::*;

    // Mode-dependent next value; SR with both terms high holds.
    always_comb begin
        unique case (mode)
            MODE_D:  nxt = tbl;
            MODE_T:  nxt = q ^ tbl;
            MODE_JK: nxt = (tbl & ~q) | (~ctl & q);
            MODE_SR: nxt = (tbl & ~ctl) ? 1'b1 :
                           (~tbl & ctl) ? 1'b0 : q;
            default: nxt = q;
        endcase
    end
endmodule

// File: rtl/lcell_ff.sv
// Programmable storage bit with selectable clock and enable.
// Priority: rst_n, aclr, apre (all asynchronous), then sclr, sload,
// then the enabled mode update at the selected rising edge.
// Assumes: clk_sel changes only while both clocks are low.
module lcell_ff (
    input  logic clk_a,
    input  logic clk_b,
    input  logic clk_sel,
    input  logic ena_a,
    input  logic ena_b,
    input  logic ena_sel,
    input  logic rst_n,
    input  logic aclr,
    input  logic apre,
    input  logic sclr,
    input  logic sload,
    input  logic ld_val,
    input  logic nxt,
    output logic q
);
    logic gclk;
    logic en;

    // Clock and enable source selection.
    always_comb begin
        gclk = clk_sel ? clk_b : clk_a;
        en   = ena_sel ? ena_b : ena_a;
    end

    // Storage bit with layered asynchronous and synchronous control.
    always_ff @(posedge gclk or negedge rst_n or posedge aclr or posedge apre) begin
        if (!rst_n)     q <= 1'b0;
        else if (aclr)  q <= 1'b0;
        else if (apre)  q <= 1'b1;
        else if (sclr)  q <= 1'b0;
        else if (sload) q <= ld_val;
        else if (en)    q <= nxt;
    end

    AST_SCLR_ZERO: assert property (@(posedge gclk) disable iff (!rst_n || aclr || apre)
        sclr |=> !q); // R10
    AST_SLOAD_CAPTURE: assert property (@(posedge gclk) disable iff (!rst_n || aclr || apre)
        (!sclr && sload) |=> (q == $past(ld_val))); // R11
    AST_ENA_HOLD: assert property (@(posedge gclk) disable iff (!rst_n || aclr || apre)
        (!sclr && !sload && !en) |=> $stable(q)); // R5
    AST_ENA_UPDATE: assert property (@(posedge gclk) disable iff (!rst_n || aclr || apre)
        (!sclr && !sload && en) |=> (q == $past(nxt))); // R5
    AST_ACLR_LOW: assert property (@(posedge gclk) disable iff (!rst_n)
        aclr |-> !q); // R12
    AST_APRE_HIGH: assert property (@(posedge gclk) disable iff (!rst_n || aclr)
        apre |-> q); // R13
endmodule

// File: rtl/logic_cell.sv
// Configurable logic cell: lookup table with carry slice, a flip-flop with
// D / toggle / JK / SR behaviour, and a bypass selecting the cell output.
// Assumes: LUT_INPUTS >= 4 (din[2] is the load value, din[3] a control term).
module logic_cell #(
    parameter int LUT_INPUTS = 4
) (
    input  logic                          clk_a,
    input  logic                          clk_b,
    input  logic                          rst_n,
    input  logic                          ena_a,
    input  logic                          ena_b,
    input  logic                          aclr,
    input  logic                          apre,
    input  logic                          sclr,
    input  logic                          sload,
    input  logic [(1 << LUT_INPUTS)-1:0]  cfg_mask,
    input  logic [1:0]                    cfg_mode,
    input  logic                          cfg_arith,
    input  logic                          cfg_clk_sel,
    input  logic                          cfg_ena_sel,
    input  logic                          cfg_bypass,
    input  logic [LUT_INPUTS-1:0]         din,
    input  logic                          cin,
    output logic                          comb_out,
    output logic                          reg_q,
    output logic                          cell_out,
    output logic                          cout
);
    import lcell_pkg::*;

    localparam int LOAD_BIT = 2;
    localparam int CTL_BIT  = 3;

    logic     tbl;
    logic     nxt;
    ff_mode_e mode;

    // Decode the mode field into the shared enum.
    always_comb mode = ff_mode_e'(cfg_mode);

    lcell_table #(.LUT_INPUTS(LUT_INPUTS)) u_table (
        .mask  (cfg_mask),
        .din   (din),
        .cin   (cin),
        .arith (cfg_arith),
        .tbl   (tbl),
        .cout  (cout)
    );

    lcell_update u_update (
        .mode (mode),
        .q    (reg_q),
        .tbl  (tbl),
        .ctl  (din[CTL_BIT]),
        .nxt  (nxt)
    );

    lcell_ff u_ff (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_sel (cfg_clk_sel),
        .ena_a   (ena_a),
        .ena_b   (ena_b),
        .ena_sel (cfg_ena_sel),
        .rst_n   (rst_n),
        .aclr    (aclr),
        .apre    (apre),
        .sclr    (sclr),
        .sload   (sload),
        .ld_val  (din[LOAD_BIT]),
        .nxt     (nxt),
        .q       (reg_q)
    );

    // Output routing: table result or stored bit.
    always_comb begin
        comb_out = tbl;
        cell_out = cfg_bypass ? tbl : reg_q;
    end
endmodule

// File: tb/sim_logic_cell.sv
// Bench for logic_cell: a vector table for the combinational path, then
// directed tests of the flip-flop modes, clock/enable selection and resets.
module sim_logic_cell;
    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst_n, ena_a, ena_b, aclr, apre, sclr, sload;
    logic [15:0] cfg_mask;
    logic [1:0]  cfg_mode;
    logic        cfg_arith, cfg_clk_sel, cfg_ena_sel, cfg_bypass;
    logic [3:0]  din;
    logic        cin;
    logic        comb_out, reg_q, cell_out, cout;

    int checks = 0;
    int fails  = 0;

    // {arith, mask, din, cin, expected comb_out, expected cout}
    localparam logic [23:0] VEC [13] = '{
        {1'b0, 16'hA5C3, 4'h0, 1'b0, 1'b1, 1'b0},
        {1'b0, 16'hA5C3, 4'h2, 1'b1, 1'b0, 1'b1},
        {1'b0, 16'hA5C3, 4'h7, 1'b0, 1'b1, 1'b0},
        {1'b0, 16'hA5C3, 4'h9, 1'b1, 1'b0, 1'b1},
        {1'b0, 16'hA5C3, 4'hD, 1'b0, 1'b1, 1'b0},
        {1'b0, 16'h8000, 4'hF, 1'b0, 1'b1, 1'b0},
        {1'b0, 16'h8000, 4'hE, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'hFFFF, 4'h0, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'hFFFF, 4'h1, 1'b0, 1'b1, 1'b0},
        {1'b1, 16'hFFFF, 4'h3, 1'b0, 1'b0, 1'b1},
        {1'b1, 16'hFFFF, 4'h3, 1'b1, 1'b1, 1'b1},
        {1'b1, 16'hFFFF, 4'hE, 1'b1, 1'b0, 1'b1},
        {1'b1, 16'hFFFF, 4'h4, 1'b1, 1'b1, 1'b0}
    };

    logic_cell u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .ena_a(ena_a), .ena_b(ena_b),
        .aclr(aclr), .apre(apre), .sclr(sclr), .sload(sload), .cfg_mask(cfg_mask),
        .cfg_mode(cfg_mode), .cfg_arith(cfg_arith), .cfg_clk_sel(cfg_clk_sel),
        .cfg_ena_sel(cfg_ena_sel), .cfg_bypass(cfg_bypass), .din(din), .cin(cin),
        .comb_out(comb_out), .reg_q(reg_q), .cell_out(cell_out), .cout(cout)
    );

    // 50 MHz clock A; clock B runs at half rate, rising with clock A.
    always #10 clk_a = ~clk_a;
    always @(posedge clk_a) clk_b <= ~clk_b;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One clk_a cycle: pass a rising edge, return at the falling edge.
    task automatic step();
        @(posedge clk_a);
        @(negedge clk_a);
    endtask

    // Return at a falling edge of clk_a with clk_b low.
    task automatic sync_low();
        do @(negedge clk_a); while (clk_b !== 1'b0);
    endtask

    initial begin
        repeat (5000) @(posedge clk_a);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; ena_a = 1; ena_b = 0; aclr = 0; apre = 0; sclr = 0; sload = 0;
        cfg_mask = 16'hFFFF; cfg_mode = 2'd0; cfg_arith = 0; cfg_clk_sel = 0;
        cfg_ena_sel = 0; cfg_bypass = 0; din = 4'h0; cin = 0;
        repeat (3) step();
        chk("R14 reset state", reg_q, 1'b0);
        chk("R3 register path in reset", cell_out, 1'b0);
        rst_n = 1;

        // Combinational vectors (R1, R2, R3).
        for (int i = 0; i < 13; i++) begin
            @(negedge clk_a);
            cfg_arith = VEC[i][23]; cfg_mask = VEC[i][22:7];
            din = VEC[i][6:3]; cin = VEC[i][2]; cfg_bypass = 1'b1;
            #2;
            chk(VEC[i][23] ? "R2 sum" : "R1 lookup", comb_out, VEC[i][1]);
            chk("R2 carry", cout, VEC[i][0]);
            chk("R3 bypass", cell_out, VEC[i][1]);
        end
        @(negedge clk_a);
        cfg_arith = 0; cfg_bypass = 0; din = 4'h0; cin = 0; ena_a = 0;

        // R10 synchronous clear.
        sclr = 1; step(); chk("R10 sclr", reg_q, 1'b0); sclr = 0;

        // R6 D mode with enable A.
        ena_a = 1; cfg_mask = 16'hFFFF; step(); chk("R6 D set", reg_q, 1'b1);
        cfg_mask = 16'h0000; step(); chk("R6 D clear", reg_q, 1'b0);

        // R5 enable selection.
        ena_a = 0; ena_b = 1; cfg_mask = 16'hFFFF;
        step(); chk("R5 ena_a low holds", reg_q, 1'b0);
        cfg_ena_sel = 1; step(); chk("R5 ena_b selected", reg_q, 1'b1);
        ena_b = 0; cfg_mask = 16'h0000; step(); chk("R5 ena_b low holds", reg_q, 1'b1);

        // R11 synchronous load with enable low.
        din = 4'h0; sload = 1; step(); chk("R11 load 0", reg_q, 1'b0);
        din = 4'h4; step(); chk("R11 load 1", reg_q, 1'b1);
        // R10 clear wins over load, enable low.
        sclr = 1; step(); chk("R10 sclr over sload", reg_q, 1'b0);
        sclr = 0; sload = 0; din = 4'h0;

        // R7 toggle mode.
        cfg_mode = 2'd1; ena_b = 1; cfg_mask = 16'hFFFF;
        step(); chk("R7 toggle 1", reg_q, 1'b1);
        step(); chk("R7 toggle 2", reg_q, 1'b0);
        step(); chk("R7 toggle 3", reg_q, 1'b1);
        cfg_mask = 16'h0000; step(); chk("R7 hold", reg_q, 1'b1);

        // R8 JK mode: J = table, K = din[3].
        cfg_mode = 2'd2;
        din = 4'h0; cfg_mask = 16'h0000; step(); chk("R8 JK hold", reg_q, 1'b1);
        din = 4'h8; step(); chk("R8 JK clear", reg_q, 1'b0);
        din = 4'h0; cfg_mask = 16'hFFFF; step(); chk("R8 JK set", reg_q, 1'b1);
        din = 4'h8; step(); chk("R8 JK toggle a", reg_q, 1'b0);
        step(); chk("R8 JK toggle b", reg_q, 1'b1);

        // R9 SR mode: S = table, R = din[3].
        cfg_mode = 2'd3;
        din = 4'h8; cfg_mask = 16'h0000; step(); chk("R9 SR reset", reg_q, 1'b0);
        din = 4'h0; cfg_mask = 16'hFFFF; step(); chk("R9 SR set", reg_q, 1'b1);
        din = 4'h8; step(); chk("R9 SR both high holds 1", reg_q, 1'b1);
        cfg_mask = 16'h0000; step(); chk("R9 SR reset again", reg_q, 1'b0);
        cfg_mask = 16'hFFFF; step(); chk("R9 SR both high holds 0", reg_q, 1'b0);
        din = 4'h0; cfg_mask = 16'h0000; step(); chk("R9 SR idle holds", reg_q, 1'b0);

        // R4 clock selection (D mode, enable A on).
        cfg_mode = 2'd0; cfg_ena_sel = 0; ena_a = 1; ena_b = 0;
        sync_low();
        cfg_clk_sel = 1; cfg_mask = 16'hFFFF;
        step(); chk("R4 clk_b edge updates", reg_q, 1'b1);
        cfg_mask = 16'h0000; #1;
        chk("R3 register path", cell_out, 1'b1);
        step(); chk("R4 clk_a-only edge ignored", reg_q, 1'b1);
        step(); chk("R4 next clk_b edge", reg_q, 1'b0);
        sync_low();
        cfg_clk_sel = 0; ena_a = 0;

        // R13 asynchronous preset.
        apre = 1; #2; chk("R13 preset without edge", reg_q, 1'b1);
        step(); apre = 0; step(); chk("R13 value after release", reg_q, 1'b1);
        // R12 asynchronous clear wins over preset.
        aclr = 1; apre = 1; #2; chk("R12 clear without edge", reg_q, 1'b0);
        step(); aclr = 0; apre = 0; step(); chk("R12 value after release", reg_q, 1'b0);

        // R14 chip reset mid-run, over preset.
        apre = 1; #2; step(); apre = 0; step();
        chk("R13 preset before reset", reg_q, 1'b1);
        rst_n = 0; apre = 1; #2; chk("R14 reset without edge", reg_q, 1'b0);
        step(); rst_n = 1; apre = 0; step(); chk("R14 value after release", reg_q, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule